// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM with registered inputs and a registered output. The word is 36 bits wide and is split into four 9-bit byte lanes. Every rising clock edge samples the address, chip select, write enable and the four active-low lane write enables. A read returns its word on the output register one edge after the command register took it. A write is late: its data is sampled from the input bus on the edge after the one that took its address.

Accepted write data stays in a pending-write register until the next write command's data edge, and only then does it go into the storage array. A read of the pending address therefore gets the pending lanes merged over the array word. The shared data bus is modelled as separate input, output and output-enable ports. An asynchronous active-low output enable and an asynchronous sleep input gate the driver. A small power state machine has the states RUN, ENTER, SLEEP and WAKE, with these transitions: RUN to ENTER when sleep is seen high. ENTER to SLEEP if sleep is still high, otherwise ENTER to WAKE. SLEEP to WAKE when sleep is seen low. WAKE to RUN when sleep is low, otherwise WAKE to ENTER. Commands are only taken in RUN with sleep low.

The system side must leave one idle cycle between a read and a following write. If it does not, the write wins and the read word is not driven.

Top module: `lw_sram`

## Requirements
- R1: A read (cs_n=0, we_n=1) sampled at edge N puts the addressed word on dout with dq_oe=1 after edge N+1 (with oe_n=0), and dq_oe is 0 between edges N and N+1.
- R2: Write data is taken from din on the edge after the write command's edge; din at the command edge itself has no effect on the stored word.
- R3: lane_we_n bit i (active low) selects bits [9i+8:9i]; lanes whose bit is 1 keep their stored contents.
- R4: A read whose address equals the pending-write address returns the pending data in the enabled lanes and the array contents in the other lanes.
- R5: A pending write is committed to the array when the next write's data edge occurs, so an older write is read back correctly after a newer write to another address.
- R6: With cs_n=1 the cycle is a deselect: nothing is written or read, and dq_oe is 0 after the following edge.
- R7: In the cycle after a write command's edge, dq_oe is 0 regardless of oe_n, even if a read word was loaded on that edge.
- R8: oe_n=1 forces dq_oe to 0 without waiting for a clock edge, and oe_n=0 restores it within the same cycle.
- R9: While sleep is 1, dq_oe is 0, commands are ignored and stored data is kept; cs_n must already be 1 when sleep rises.
- R10: After sleep falls, commands on the first two edges are ignored and the command on the third edge is accepted.
- R11: During and after reset, dq_oe is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write command, active low |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| addr | input | AW | Word address |
| din | input | 36 | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dout | output | 36 | Read data from the output register |
| dq_oe | output | 1 | Bus driver enable |

## Verification
Read data and the driver enable are due one edge after the command edge. Write data is due on the edge after the write command. A pending word reaches the array on the next write's data edge. Wake-up lets the third edge's command through. oe_n and sleep act within a cycle. The bench drives every input at a falling edge and samples at the next falling edge. Each edge's result is therefore read half a period after the edge that produced it, counted edge by edge from the command. The asynchronous checks are read one time unit after the input changes, with no clock edge in between.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LANE_W_DEF = 9;
    localparam int LANES_DEF  = 4;
    localparam int AW_DEF     = 4;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_ENTER,
        ST_SLEEP,
        ST_WAKE
    } pwr_state_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_WRITE
    } op_e;

endpackage

// File: rtl/lw_sram_pwr.sv
module lw_sram_pwr
    import lw_sram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    output pwr_state_e state,
    output logic       accept,
    output logic       awake
);

    pwr_state_e state_q;
    pwr_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (sleep)  state_d = ST_ENTER;
            ST_ENTER: state_d = sleep ? ST_SLEEP : ST_WAKE;
            ST_SLEEP: if (!sleep) state_d = ST_WAKE;
            ST_WAKE:  state_d = sleep ? ST_ENTER : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        state  = state_q;
        awake  = (state_q == ST_RUN);
        accept = (state_q == ST_RUN) && !sleep;
    end

endmodule

// File: rtl/lw_sram_cmd.sv
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int AW     = AW_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output op_e              op_q,
    output logic [AW-1:0]    cmd_addr,
    output logic             pend_vld,
    output logic [AW-1:0]    pend_addr,
    output logic [LANES-1:0] pend_en,
    output logic [DW-1:0]    pend_data,
    output logic             commit
);

    op_e              op_d;
    logic [LANES-1:0] cmd_en;

    always_comb begin
        op_d = OP_IDLE;
        if (accept && !cs_n) begin
            op_d = we_n ? OP_READ : OP_WRITE;
        end
    end

    // command register: first pipeline stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_IDLE;
            cmd_addr <= '0;
            cmd_en   <= '0;
        end else begin
            op_q     <= op_d;
            cmd_addr <= addr;
            cmd_en   <= ~lane_we_n;
        end
    end

    // pending-write register, loaded on the late data edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            pend_en   <= '0;
            pend_data <= '0;
        end else if (op_q == OP_WRITE) begin
            pend_vld  <= 1'b1;
            pend_addr <= cmd_addr;
            pend_en   <= cmd_en;
            pend_data <= din;
        end
    end

    // the older pending word leaves for the array on the same edge
    assign commit = (op_q == OP_WRITE) && pend_vld;

endmodule

// File: rtl/lw_sram_store.sv
module lw_sram_store
    import lw_sram_pkg::*;
#(
    parameter int AW     = AW_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [LANES-1:0] wr_lane_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lane_en[g]) begin
                bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = bank[rd_addr];
    end

endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath
    import lw_sram_pkg::*;
#(
    parameter int AW     = AW_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    arr_data,
    input  logic             pend_vld,
    input  logic [AW-1:0]    pend_addr,
    input  logic [LANES-1:0] pend_en,
    input  logic [DW-1:0]    pend_data,
    output logic [DW-1:0]    q_data,
    output logic             q_vld
);

    logic          hit;
    logic [DW-1:0] merged;

    assign hit = pend_vld && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_en[g])
                                          ? pend_data[g*LANE_W +: LANE_W]
                                          : arr_data[g*LANE_W +: LANE_W];
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_data <= '0;
        end else begin
            q_vld <= (op == OP_READ);
            if (op == OP_READ) begin
                q_data <= merged;
            end
        end
    end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW     = AW_DEF,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic             oe_n,
    input  logic             sleep,
    output logic [DW-1:0]    dout,
    output logic             dq_oe
);

    pwr_state_e       pwr_state;
    logic             cmd_accept;
    logic             awake;
    op_e              op_q;
    logic [AW-1:0]    cmd_addr;
    logic             pend_vld;
    logic [AW-1:0]    pend_addr;
    logic [LANES-1:0] pend_en;
    logic [DW-1:0]    pend_data;
    logic             commit;
    logic [DW-1:0]    arr_data;
    logic [DW-1:0]    q_data;
    logic             rd_vld;

    lw_sram_pwr i_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .state  (pwr_state),
        .accept (cmd_accept),
        .awake  (awake)
    );

    lw_sram_cmd #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (cmd_accept),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .lane_we_n (lane_we_n),
        .addr      (addr),
        .din       (din),
        .op_q      (op_q),
        .cmd_addr  (cmd_addr),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_en   (pend_en),
        .pend_data (pend_data),
        .commit    (commit)
    );

    lw_sram_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_store (
        .clk        (clk),
        .wr_en      (commit),
        .wr_addr    (pend_addr),
        .wr_lane_en (pend_en),
        .wr_data    (pend_data),
        .rd_addr    (cmd_addr),
        .rd_data    (arr_data)
    );

    lw_sram_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_q),
        .rd_addr   (cmd_addr),
        .arr_data  (arr_data),
        .pend_vld  (pend_vld),
        .pend_addr (pend_addr),
        .pend_en   (pend_en),
        .pend_data (pend_data),
        .q_data    (q_data),
        .q_vld     (rd_vld)
    );

    // driver: registered word, gated asynchronously
    assign dout  = q_data;
    assign dq_oe = rd_vld && !oe_n && !sleep && awake && (op_q != OP_WRITE);

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
    import lw_sram_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       sleep,
    input logic       dq_oe,
    input logic       accept,
    input pwr_state_e pwr_state,
    input logic       q_vld
);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cs_n && we_n) |-> ##2 q_vld); // R1

    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cs_n && !we_n) |=> !dq_oe); // R7

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cs_n) |-> ##2 !dq_oe); // R6

    AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R8

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe); // R9

    AST_SLEEP_ENTRY_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> cs_n); // R9

    AST_WAKE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == ST_SLEEP) |=> (pwr_state != ST_RUN)); // R10

endmodule

bind lw_sram lw_sram_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .sleep     (sleep),
    .dq_oe     (dq_oe),
    .accept    (cmd_accept),
    .pwr_state (pwr_state),
    .q_vld     (rd_vld)
);

// File: tb/test_lw_sram.sv
module test_lw_sram;

    localparam int CLK_P  = 10;
    localparam int AW     = 4;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DW     = LANES * LANE_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cs_n;
    logic             we_n;
    logic [LANES-1:0] lane_we_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    din;
    logic             oe_n;
    logic             sleep;
    logic [DW-1:0]    dout;
    logic             dq_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    lw_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_lw_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .lane_we_n (lane_we_n),
        .addr      (addr),
        .din       (din),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .dout      (dout),
        .dq_oe     (dq_oe)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // lanes whose active-low enable is 0 take the new data
    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                            input logic [DW-1:0] new_w,
                                            input logic [LANES-1:0] ln_n);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (!ln_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_cmd(input logic c, input logic w, input logic [LANES-1:0] ln, input logic [AW-1:0] a);
        cs_n = c; we_n = w; lane_we_n = ln; addr = a;
    endtask

    task automatic idle();
        set_cmd(1'b1, 1'b1, 4'hF, '0);
    endtask

    // write command, then its data one edge later; command-edge din is junk (R2)
    task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] ln, input logic [DW-1:0] d);
        set_cmd(1'b0, 1'b0, ln, a);
        din = ~d;
        step();
        idle();
        din = d;
        step();
        din = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        set_cmd(1'b0, 1'b1, 4'hF, a);
        step();
        idle();
        chk({"R1 not yet driven / ", req}, {35'd0, dq_oe}, 36'd0);
        step();
        chk({"R1 driven / ", req}, {35'd0, dq_oe}, 36'd1);
        chk(req, dout, exp);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [DW-1:0] VA = 36'h1_2345_6789;
    localparam logic [DW-1:0] VB = 36'hA_BCDE_F012;
    localparam logic [DW-1:0] VC = 36'h5_A5A5_A5A5;
    localparam logic [DW-1:0] VD = 36'h3_0F0F_0F0F;
    localparam logic [DW-1:0] VE = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] VF = 36'h0_1111_2222;
    localparam logic [DW-1:0] VG = 36'h7_7654_3210;
    localparam logic [DW-1:0] VH = 36'h0_0000_0000;

    logic [DW-1:0] exp3;

    task automatic t_reset();
        rst_n = 1'b0; oe_n = 1'b0; sleep = 1'b0; din = '0;
        idle();
        repeat (3) step();
        chk("R11 in reset", {35'd0, dq_oe}, 36'd0);
        rst_n = 1'b1;
        step();
        chk("R11 after reset", {35'd0, dq_oe}, 36'd0);
    endtask

    task automatic t_basic();
        wr(4'd3, 4'h0, VA);
        wr(4'd4, 4'h0, VB);
        rd(4'd3, VA, "R5 older write committed, R2 late data");
        rd(4'd4, VB, "R4 full-word bypass");
    endtask

    task automatic t_lanes();
        wr(4'd3, 4'b1010, VC);
        exp3 = merge(VA, VC, 4'b1010);
        rd(4'd3, exp3, "R4 lane merge over array");
        wr(4'd6, 4'h0, VD);
        rd(4'd3, exp3, "R3 disabled lanes kept");
    endtask

    task automatic t_deselect();
        set_cmd(1'b1, 1'b0, 4'h0, 4'd3);
        din = VE;
        step();
        chk("R6 deselect quiet", {35'd0, dq_oe}, 36'd0);
        step();
        chk("R6 deselect quiet 2", {35'd0, dq_oe}, 36'd0);
        wr(4'd7, 4'h0, VF);
        rd(4'd3, exp3, "R6 deselect wrote nothing");
        rd(4'd6, VD, "R5 commit on next write");
    endtask

    task automatic t_write_hiz();
        set_cmd(1'b0, 1'b1, 4'hF, 4'd6);
        step();
        set_cmd(1'b0, 1'b0, 4'h0, 4'd8);
        din = ~VG;
        step();
        chk("R7 write overrides loaded read", {35'd0, dq_oe}, 36'd0);
        idle();
        din = VG;
        step();
        chk("R7 write data cycle", {35'd0, dq_oe}, 36'd0);
        din = '0;
        rd(4'd8, VG, "R2 late data after back-to-back read");
    endtask

    task automatic t_oe();
        set_cmd(1'b0, 1'b1, 4'hF, 4'd7);
        step();
        idle();
        step();
        chk("R8 read word", dout, VF);
        oe_n = 1'b1;
        #1;
        chk("R8 oe_n high", {35'd0, dq_oe}, 36'd0);
        oe_n = 1'b0;
        #1;
        chk("R8 oe_n low again", {35'd0, dq_oe}, 36'd1);
    endtask

    task automatic t_sleep();
        set_cmd(1'b0, 1'b1, 4'hF, 4'd6);
        step();
        idle();
        step();
        chk("R9 driven before sleep", {35'd0, dq_oe}, 36'd1);
        sleep = 1'b1;
        #1;
        chk("R9 sleep forces off", {35'd0, dq_oe}, 36'd0);
        step();
        set_cmd(1'b0, 1'b0, 4'h0, 4'd3);
        din = VH;
        repeat (4) step();
        idle();
        repeat (2) step();
        chk("R9 still off", {35'd0, dq_oe}, 36'd0);
        sleep = 1'b0;
        set_cmd(1'b0, 1'b1, 4'hF, 4'd3);
        step();
        step();
        chk("R10 first wake edge ignored", {35'd0, dq_oe}, 36'd0);
        step();
        chk("R10 second wake edge ignored", {35'd0, dq_oe}, 36'd0);
        idle();
        step();
        chk("R10 third wake edge accepted", {35'd0, dq_oe}, 36'd1);
        chk("R9 data kept, sleep write ignored", dout, exp3);
        rd(4'd8, VG, "R9 pending word kept");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_lanes();
        t_deselect();
        t_write_hiz();
        t_oe();
        t_sleep();
        repeat (2) step();
        finish_run();
    end

endmodule